// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block lets software switch a set of on-chip modules between an enabled and a disabled state, and brings their shared power domain up first when it is off. Software writes a desired state into a per-module control register. Nothing changes until software writes a go bit into the command register. A transition then runs for a fixed number of cycles, and the busy bit for the domain stays set until it ends. Software polls that bit to learn when the new states are in force.

If the domain is off and software has asked for power-on in the domain control register before the go, the sequencer stops partway. It raises a power request, both on a pin and in a readable register, and waits. Software then sets the power-good bit in domain control. The sequencer runs a ramp phase, marks the domain as powered, applies the module states, and clears busy. The external switch, clock gates and resets are not part of this block. They see only the request pin, the domain-on pin and the per-module enable pins.

All registers sit on a simple 32-bit bus with a 12-bit byte address. Writes take effect at the clock edge on which `bus_sel` and `bus_we` are both high. Reads are combinational from `bus_addr`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the domain is off, every module's current and pending state is code 2 (disabled), and the power request, busy and domain status bits, as well as the domain control register, read as zero.
- R2: Writing a module control register (0xA00 + 4*id) stores bits [4:0] as that module's pending state. Those bits read back and all other bits read zero. The module status register (0x800 + 4*id) keeps its old value until a transition applies the pending state.
- R3: With the domain powered, or with the power-on bit clear, a write to the command register (0x120) with bit DOM_ID set makes bit DOM_ID of the transition status register (0x128) read 1 for PHASE_CYC cycles, starting at the write edge. When it clears, each module's status bits [4:0] equal its pending code, where 3 means enabled and 2 means disabled, and `mod_on[id]` is high exactly for modules in state 3.
- R4: With the domain off and bit 0 of domain control (0x304) set, a go raises `pwr_req` and bit DOM_ID of the power request register (0x070). Busy then holds for as long as bit 8 of domain control stays clear.
- R5: One cycle after bit 8 of domain control is set, the request drops and a ramp of PHASE_CYC cycles begins. The domain then reads as powered, in bit 0 of domain status (0x200) and on `dom_on`, and it stays powered. An apply phase of PHASE_CYC cycles follows, and busy clears after it.
- R6: A go written while a transition is busy is ignored and does not lengthen the busy window.
- R7: A command write without bit DOM_ID set starts nothing.
- R8: A pending code other than 2 or 3 leaves the module's current state unchanged when a transition applies, though the code still reads back from the control register.
- R9: The command register, addresses past the last module and every other unused offset read as zero.
- R10: A go issued with the domain off and the power-on bit clear applies module states with no power request, and the domain stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwr_req | output | 1 | Request to the external power switch |
| dom_on | output | 1 | Domain is powered |
| mod_on | output | N_MOD | Per-module enable (current state is 3) |

## Verification
Four transition patterns are run. The first is a power-up from off with a long wait before power-good, which shows that the handshake really stalls the sequencer. The second is a go with the domain off and power-on clear, which shows the no-power path is separate from the handshake path. The third is a go with the domain already on, which gives the short busy window. The fourth is a go with an illegal pending code, which shows that only codes 2 and 3 are applied. Repeated go writes during busy, and command writes that lack the domain bit, show that the busy window is fixed at the first accepted go. A behavioural model checks the pins and the read data on every cycle, and counted busy windows pin down the cycle counts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_WAIT_PG = 2'd1,
    SQ_RAMP    = 2'd2,
    SQ_APPLY   = 2'd3
  } seq_state_e;

  localparam logic [4:0] ST_ON  = 5'd3;
  localparam logic [4:0] ST_OFF = 5'd2;

  localparam logic [11:0] A_PREQ  = 12'h070;
  localparam logic [11:0] A_GO    = 12'h120;
  localparam logic [11:0] A_BUSY  = 12'h128;
  localparam logic [11:0] A_DSTAT = 12'h200;
  localparam logic [11:0] A_DCTL  = 12'h304;
  localparam logic [11:0] A_MSTAT = 12'h800;
  localparam logic [11:0] A_MCTL  = 12'hA00;

  // only the two defined codes may become a module's current state
  function automatic logic code_ok(input logic [4:0] c);
    return (c == ST_ON) || (c == ST_OFF);
  endfunction

  // word-aligned address inside a bank of n registers starting at base
  function automatic logic in_bank(input logic [11:0] a, input logic [11:0] base, input int n);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + 4 * n) && (a[1:0] == 2'b00);
  endfunction

  function automatic int slot_of(input logic [11:0] a, input logic [11:0] base);
    return (int'(a) - int'(base)) / 4;
  endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_go,
  input  logic pon_req,
  input  logic pgood,
  output logic busy,
  output logic pwr_req,
  output logic dom_on,
  output logic apply
);

  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          dom_q;
  logic          phase_done;

  assign phase_done = (cnt == '0);
  assign busy       = (state != SQ_IDLE);
  assign pwr_req    = (state == SQ_WAIT_PG);
  assign dom_on     = dom_q;
  assign apply      = (state == SQ_APPLY) && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      dom_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (cmd_go) begin
          cnt   <= LAST;
          state <= (!dom_q && pon_req) ? SQ_WAIT_PG : SQ_APPLY;
        end
        SQ_WAIT_PG: if (pgood) begin
          cnt   <= LAST;
          state <= SQ_RAMP;
        end
        SQ_RAMP: if (phase_done) begin
          dom_q <= 1'b1;
          cnt   <= LAST;
          state <= SQ_APPLY;
        end else begin
          cnt <= cnt - 1'b1;
        end
        SQ_APPLY: if (phase_done) state <= SQ_IDLE;
                  else cnt <= cnt - 1'b1;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) pwr_req |-> busy);
  // R5
  dom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) dom_on |=> dom_on);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_go));
  // R3
  apply_end_chk: assert property (@(posedge clk) disable iff (!rst_n) apply |=> !busy);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);

endmodule

// File: rtl/pwr_seq_modbank.sv
module pwr_seq_modbank
  import pwr_seq_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_MOD-1:0]      wr_en,
  input  logic [4:0]            wr_code,
  input  logic                  apply,
  output logic [N_MOD-1:0][4:0] nxt,
  output logic [N_MOD-1:0][4:0] cur,
  output logic [N_MOD-1:0]      mod_on
);

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nxt[i] <= ST_OFF;
        cur[i] <= ST_OFF;
      end else begin
        if (apply && code_ok(nxt[i])) cur[i] <= nxt[i];
        if (wr_en[i]) nxt[i] <= wr_code;
      end
    end

    assign mod_on[i] = (cur[i] == ST_ON);

    // R8
    cur_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) code_ok(cur[i]));
    // R3
    cur_change_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cur[i]) |-> $past(apply));
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_MOD     = 4,
  parameter int PHASE_CYC = 4,
  parameter int DOM_ID    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             pwr_req,
  output logic             dom_on,
  output logic [N_MOD-1:0] mod_on
);

  localparam int IW = (N_MOD > 1) ? $clog2(N_MOD) : 1;

  logic                  wr;
  logic                  cmd_go;
  logic                  pon_q;
  logic                  pg_q;
  logic                  busy;
  logic                  apply;
  logic [N_MOD-1:0]      mctl_we;
  logic [N_MOD-1:0][4:0] nxt;
  logic [N_MOD-1:0][4:0] cur;

  assign wr     = bus_sel && bus_we;
  assign cmd_go = wr && (bus_addr == A_GO) && bus_wdata[DOM_ID];

  for (genvar i = 0; i < N_MOD; i++) begin : g_dec
    assign mctl_we[i] = wr && (bus_addr == A_MCTL + 12'(4 * i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pon_q <= 1'b0;
      pg_q  <= 1'b0;
    end else if (wr && bus_addr == A_DCTL) begin
      pon_q <= bus_wdata[0];
      pg_q  <= bus_wdata[8];
    end
  end

  pwr_seq_fsm #(.PHASE_CYC(PHASE_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_go  (cmd_go),
    .pon_req (pon_q),
    .pgood   (pg_q),
    .busy    (busy),
    .pwr_req (pwr_req),
    .dom_on  (dom_on),
    .apply   (apply)
  );

  pwr_seq_modbank #(.N_MOD(N_MOD)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mctl_we),
    .wr_code (bus_wdata[4:0]),
    .apply   (apply),
    .nxt     (nxt),
    .cur     (cur),
    .mod_on  (mod_on)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PREQ)      bus_rdata[DOM_ID] = pwr_req;
    else if (bus_addr == A_BUSY) bus_rdata[DOM_ID] = busy;
    else if (bus_addr == A_DSTAT) bus_rdata[0] = dom_on;
    else if (bus_addr == A_DCTL) begin
      bus_rdata[0] = pon_q;
      bus_rdata[8] = pg_q;
    end
    else if (in_bank(bus_addr, A_MSTAT, N_MOD)) bus_rdata[4:0] = cur[IW'(slot_of(bus_addr, A_MSTAT))];
    else if (in_bank(bus_addr, A_MCTL, N_MOD))  bus_rdata[4:0] = nxt[IW'(slot_of(bus_addr, A_MCTL))];
  end

  // R4
  req_pin_chk: assert property (@(posedge clk) disable iff (!rst_n) pwr_req |-> !dom_on);

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  localparam int N  = 4;
  localparam int P  = 4;
  localparam int DI = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_req;
  logic        dom_on;
  logic [N-1:0] mod_on;

  int total = 0;
  int bad = 0;

  pwr_seq_ctrl #(.N_MOD(N), .PHASE_CYC(P), .DOM_ID(DI)) i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_req(pwr_req), .dom_on(dom_on), .mod_on(mod_on)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: phase 0 idle, 1 waiting for power good, 2 ramp, 3 apply
  int m_ph, m_left, m_dom, m_pon, m_pg;
  int m_nxt[N];
  int m_cur[N];

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] r;
    r = '0;
    if (a == 'h070) r[DI] = (m_ph == 1);
    else if (a == 'h128) r[DI] = (m_ph != 0);
    else if (a == 'h200) r[0] = (m_dom != 0);
    else if (a == 'h304) begin r[0] = (m_pon != 0); r[8] = (m_pg != 0); end
    else if (a >= 'h800 && a < 'h800 + 4*N && a % 4 == 0) r = m_cur[(a - 'h800) / 4];
    else if (a >= 'hA00 && a < 'hA00 + 4*N && a % 4 == 0) r = m_nxt[(a - 'hA00) / 4];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_dom = 0; m_pon = 0; m_pg = 0;
      for (int k = 0; k < N; k++) begin m_nxt[k] = 2; m_cur[k] = 2; end
    end else begin
      bit wr, go, fin;
      int old_nxt[N];
      wr = bus_sel && bus_we;
      go = wr && bus_addr == 12'h120 && bus_wdata[DI];
      for (int k = 0; k < N; k++) old_nxt[k] = m_nxt[k];
      fin = (m_ph == 3 && m_left == 1);
      if (m_ph == 0) begin
        if (go) begin m_left = P; m_ph = (m_dom == 0 && m_pon != 0) ? 1 : 3; end
      end else if (m_ph == 1) begin
        if (m_pg != 0) begin m_ph = 2; m_left = P; end
      end else if (m_ph == 2) begin
        if (m_left == 1) begin m_dom = 1; m_ph = 3; m_left = P; end
        else m_left--;
      end else begin
        if (m_left == 1) m_ph = 0; else m_left--;
      end
      if (fin)
        for (int k = 0; k < N; k++)
          if (old_nxt[k] == 2 || old_nxt[k] == 3) m_cur[k] = old_nxt[k];
      if (wr && bus_addr == 12'h304) begin m_pon = bus_wdata[0]; m_pg = bus_wdata[8]; end
      for (int k = 0; k < N; k++)
        if (wr && int'(bus_addr) == 'hA00 + 4*k) m_nxt[k] = int'(bus_wdata[4:0]);
    end
    #5;
    begin
      logic [N-1:0] exp_on;
      for (int k = 0; k < N; k++) exp_on[k] = (m_cur[k] == 3);
      check("R4 model pwr_req", {31'b0, pwr_req}, {31'b0, m_ph == 1});
      check("R5 model dom_on", {31'b0, dom_on}, {31'b0, m_dom != 0});
      check("R3 model mod_on", {28'b0, mod_on}, {28'b0, exp_on});
      check("R2 model rdata", bus_rdata, m_read(int'(bus_addr)));
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #3;
    check(req, bus_rdata, exp);
  endtask

  // called at a falling edge; counts later samples with busy set
  task automatic busy_len(output int n);
    n = 0;
    bus_addr = 12'h128;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #6;
      if (bus_rdata[DI]) n++; else break;
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(12'h800, 32'd2, "R1 mstat0");
    rd_chk(12'hA0C, 32'd2, "R1 mctl3");
    rd_chk(12'h200, 32'd0, "R1 dstat");
    rd_chk(12'h128, 32'd0, "R1 busy");
    rd_chk(12'h070, 32'd0, "R1 preq");
    rd_chk(12'h304, 32'd0, "R1 dctl");
    // R2 next-state field
    wr_reg(12'hA00, 32'd3);
    wr_reg(12'hA04, 32'hFFFF_FFE3);
    rd_chk(12'hA04, 32'd3, "R2 mctl1 field");
    rd_chk(12'h800, 32'd2, "R2 mstat0 unchanged");
    // R7 wrong domain bit
    wr_reg(12'h120, 32'h1);
    rd_chk(12'h128, 32'd0, "R7 no busy");
    // R10 domain off, no power-on: mod3 enabled without handshake
    wr_reg(12'hA0C, 32'd3);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h120; bus_wdata = 32'h2;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    busy_len(n);
    check("R10 busy len", n, P - 1);
    rd_chk(12'h80C, 32'd3, "R10 mstat3");
    rd_chk(12'h200, 32'd0, "R10 still off");
    rd_chk(12'h800, 32'd3, "R10 mstat0");
    // undo mod0/mod1 enables happened too; set them back off for the power path
    wr_reg(12'hA00, 32'd2);
    wr_reg(12'hA04, 32'd2);
    wr_reg(12'h120, 32'h2);
    repeat (P + 2) @(negedge clk);
    rd_chk(12'h800, 32'd2, "R10 mstat0 off");
    // R4 power-up path
    wr_reg(12'hA00, 32'd3);
    wr_reg(12'hA04, 32'd3);
    wr_reg(12'h304, 32'h1);
    wr_reg(12'h120, 32'h2);
    rd_chk(12'h070, 32'h2, "R4 preq reg");
    check("R4 preq pin", {31'b0, pwr_req}, 32'd1);
    repeat (10) @(negedge clk);
    rd_chk(12'h128, 32'h2, "R4 still busy");
    wr_reg(12'h120, 32'h2);
    rd_chk(12'h800, 32'd2, "R6 no apply while waiting");
    // R5 power good
    wr_reg(12'h304, 32'h101);
    busy_len(n);
    check("R5 busy len", n, 2 * P);
    rd_chk(12'h200, 32'd1, "R5 dstat");
    rd_chk(12'h800, 32'd3, "R5 mstat0");
    rd_chk(12'h070, 32'd0, "R5 preq clear");
    check("R5 mod_on", {28'b0, mod_on}, 32'hB);
    // R3 direct path with domain on, R6 second go ignored
    wr_reg(12'hA00, 32'd2);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h120; bus_wdata = 32'h2;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    busy_len(n);
    check("R6 busy not stretched", n, P - 2);
    rd_chk(12'h800, 32'd2, "R3 mstat0 off");
    check("R3 mod_on", {28'b0, mod_on}, 32'hA);
    // R8 illegal code
    wr_reg(12'hA08, 32'd5);
    wr_reg(12'h120, 32'h2);
    repeat (P + 2) @(negedge clk);
    rd_chk(12'h808, 32'd2, "R8 mstat2 kept");
    rd_chk(12'hA08, 32'd5, "R8 mctl2 readback");
    // R9 unused offsets
    rd_chk(12'h120, 32'd0, "R9 cmd reads 0");
    rd_chk(12'h124, 32'd0, "R9 gap");
    rd_chk(12'h810, 32'd0, "R9 past last mstat");
    rd_chk(12'hA10, 32'd0, "R9 past last mctl");
    rd_chk(12'h802, 32'd0, "R9 unaligned");
    rd_chk(12'h304, 32'h101, "R9 dctl kept");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule